// File: doc/BRIEF.md
# Stochastic Synapse Weight Counter with Momentum

This block stores one synaptic weight for a stochastic-arithmetic neural network and trains it from a bit stream. Each clock brings one bit of the error-product stream. That bit moves a momentum counter up or down. The momentum counter is coded into a second bit stream, and that stream moves the weight counter. The result is a smoothed update: the weight follows the average trend of the error stream rather than each single bit, and it changes by at most one step per clock. Both counters saturate at their ends instead of wrapping.

The weight is also sent out as a bipolar stochastic stream. On each cycle the stored value is compared against a random word that the caller supplies. The binary weight is available too.

A run-time length select chooses between two settings:
- **Full length:** fine steps and full precision.
- **Shortened length:** one bit less on each counter, coarser steps of two, so learning is faster and accuracy is lower.

A learn-enable input freezes both counters while the weight stream keeps running.

Top module: `stoch_weight_cell`

## Requirements
- R1: While `rst` is high at a clock edge, the weight counter loads 2^(WGT_W-1) and the momentum counter loads 2^(MOM_W-1). These midpoints stand for zero. `wgt_val` shows the weight midpoint from the next cycle on.
- R2: When `learn_en` is high, the momentum counter moves up one step on an `upd_bit` of 1 and down one step on a 0. It saturates at 0 and at 2^MOM_W-1.
- R3: When `learn_en` is high, the momentum stream bit decides the weight step. The bit is 1 when the momentum counter is greater than `rnd_mom`, compared at the selected length. On a 1 the weight counter moves up one step; on a 0 it moves down one step.
- R4: The weight counter saturates at 0 and at 2^WGT_W-1 and never wraps.
- R5: `len_sel` = 1 selects full length: the step is 1 and comparisons use all bits. `len_sel` = 0 selects shortened length: the step is 2, and comparisons use only bits [W-1:1] of both the counter and the random word. Stored values are kept when `len_sel` changes.
- R6: When `learn_en` is low, both counters hold their values while `wgt_bit` keeps following `rnd_wgt`.
- R7: `wgt_bit` is combinational and equals 1 exactly when the weight counter is greater than `rnd_wgt`, compared at the selected length.
- R8: Between two consecutive cycles, `wgt_val` changes by at most one step of the selected length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| learn_en | input | 1 | 1 = counters update; 0 = weight frozen |
| len_sel | input | 1 | 1 = full length; 0 = shortened length |
| upd_bit | input | 1 | Error-product stream bit |
| rnd_mom | input | MOM_W | Random word used to code the momentum counter |
| rnd_wgt | input | WGT_W | Random word used to code the weight counter |
| wgt_bit | output | 1 | Weight stochastic stream bit |
| wgt_val | output | WGT_W | Binary weight value |

## Verification
The bench uses the default widths: 12 bits for the weight and 15 bits for the momentum.

With these widths, driving the weight from its midpoint to either end takes about 2048 cycles of steady stimulus. Both saturation ends are therefore reached inside directed phases, alongside long random runs at each length setting.

A mid-run change of length setting is also exercised. It shows that the stored values survive the switch and that odd values left over from full-length mode saturate correctly under steps of two.

// File: rtl/stoch_weight_pkg.sv
package stoch_weight_pkg;

    typedef enum logic {
        LEN_SHORT = 1'b0,
        LEN_FULL  = 1'b1
    } len_mode_e;

    typedef struct packed {
        logic      en;
        logic      up;
        len_mode_e mode;
    } cnt_ctrl_t;

    function automatic int unsigned step_of(len_mode_e m);
        return (m == LEN_FULL) ? 1 : 2;
    endfunction

endpackage

// File: rtl/sat_step_counter.sv
module sat_step_counter
    import stoch_weight_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_ctrl_t    ctrl,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MID  = W'(1) << (W - 1);
    localparam logic [W:0]   MAXV = {1'b0, {W{1'b1}}};

    logic [W:0] step;
    logic [W:0] cur;
    logic [W:0] nxt;

    always_comb begin
        step = (W+1)'(step_of(ctrl.mode));
        cur  = {1'b0, q};
        if (ctrl.up) begin
            if (cur > MAXV - step) nxt = MAXV;
            else                   nxt = cur + step;
        end else begin
            if (cur < step) nxt = '0;
            else            nxt = cur - step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          q <= MID;
        else if (ctrl.en) q <= nxt[W-1:0];
    end

endmodule

// File: rtl/stream_coder.sv
module stream_coder
    import stoch_weight_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] rnd,
    input  len_mode_e    mode,
    output logic         bit_o
);
    always_comb begin
        if (mode == LEN_FULL) bit_o = (val > rnd);
        else                  bit_o = (val[W-1:1] > rnd[W-1:1]);
    end
endmodule

// File: rtl/stoch_weight_cell.sv
module stoch_weight_cell
    import stoch_weight_pkg::*;
#(
    parameter int WGT_W = 12,
    parameter int MOM_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             learn_en,
    input  logic             len_sel,
    input  logic             upd_bit,
    input  logic [MOM_W-1:0] rnd_mom,
    input  logic [WGT_W-1:0] rnd_wgt,
    output logic             wgt_bit,
    output logic [WGT_W-1:0] wgt_val
);
    len_mode_e        mode;
    cnt_ctrl_t        mom_ctrl;
    cnt_ctrl_t        wgt_ctrl;
    logic [MOM_W-1:0] mom_q;
    logic             mom_bit;

    assign mode = len_mode_e'(len_sel);

    assign mom_ctrl = '{en: learn_en, up: upd_bit, mode: mode};
    assign wgt_ctrl = '{en: learn_en, up: mom_bit, mode: mode};

    sat_step_counter #(.W(MOM_W)) u_mom_cnt (
        .clk  (clk),
        .rst  (rst),
        .ctrl (mom_ctrl),
        .q    (mom_q)
    );

    stream_coder #(.W(MOM_W)) u_mom_coder (
        .val   (mom_q),
        .rnd   (rnd_mom),
        .mode  (mode),
        .bit_o (mom_bit)
    );

    sat_step_counter #(.W(WGT_W)) u_wgt_cnt (
        .clk  (clk),
        .rst  (rst),
        .ctrl (wgt_ctrl),
        .q    (wgt_val)
    );

    stream_coder #(.W(WGT_W)) u_wgt_coder (
        .val   (wgt_val),
        .rnd   (rnd_wgt),
        .mode  (mode),
        .bit_o (wgt_bit)
    );

endmodule

// File: rtl/stoch_weight_cell_chk.sv
module stoch_weight_cell_chk #(
    parameter int WGT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             learn_en,
    input logic             len_sel,
    input logic [WGT_W-1:0] rnd_wgt,
    input logic             wgt_bit,
    input logic [WGT_W-1:0] wgt_val
);
    localparam logic [WGT_W-1:0] MID  = WGT_W'(1) << (WGT_W - 1);
    localparam logic [WGT_W-1:0] MAXV = {WGT_W{1'b1}};

    // R1: the cycle after reset shows the midpoint
    p_reset_mid_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wgt_val == MID));

    // R6: frozen weight while learning is off
    p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        !learn_en |=> $stable(wgt_val));

    // R8: at most one step per cycle, full length
    p_step_full_r8: assert property (@(posedge clk) disable iff (rst)
        (learn_en && len_sel) |=>
        ((wgt_val >= $past(wgt_val)) ? (wgt_val - $past(wgt_val) <= 1)
                                     : ($past(wgt_val) - wgt_val <= 1)));

    // R8: at most one step per cycle, shortened length
    p_step_short_r8: assert property (@(posedge clk) disable iff (rst)
        (learn_en && !len_sel) |=>
        ((wgt_val >= $past(wgt_val)) ? (wgt_val - $past(wgt_val) <= 2)
                                     : ($past(wgt_val) - wgt_val <= 2)));

    // R4: no wrap at the top
    p_no_wrap_top_r4: assert property (@(posedge clk) disable iff (rst)
        (wgt_val == MAXV) |=> (wgt_val >= MAXV - 2));

    // R4: no wrap at the bottom
    p_no_wrap_bot_r4: assert property (@(posedge clk) disable iff (rst)
        (wgt_val == '0) |=> (wgt_val <= 2));

    // R7: all-ones random word never yields a 1
    p_bit_low_r7: assert property (@(posedge clk) disable iff (rst)
        (rnd_wgt == MAXV) |-> !wgt_bit);

    // R7: zero random word with weight of two or more always yields a 1
    p_bit_high_r7: assert property (@(posedge clk) disable iff (rst)
        ((rnd_wgt == '0) && (wgt_val >= 2)) |-> wgt_bit);

endmodule

bind stoch_weight_cell stoch_weight_cell_chk #(.WGT_W(WGT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .learn_en (learn_en),
    .len_sel  (len_sel),
    .rnd_wgt  (rnd_wgt),
    .wgt_bit  (wgt_bit),
    .wgt_val  (wgt_val)
);

// File: tb/stoch_weight_cell_bench.sv
`timescale 1ns/1ps
module stoch_weight_cell_bench;
    localparam int WW = 12;
    localparam int WM = 15;

    logic          clk = 1'b0;
    logic          rst;
    logic          learn_en;
    logic          len_sel;
    logic          upd_bit;
    logic [WM-1:0] rnd_mom;
    logic [WW-1:0] rnd_wgt;
    logic          wgt_bit;
    logic [WW-1:0] wgt_val;

    int vectors = 0;
    int miscompares = 0;
    int m_w;
    int m_m;

    always #2.5 clk = ~clk;

    stoch_weight_cell #(.WGT_W(WW), .MOM_W(WM)) u_stoch_weight_cell (
        .clk(clk), .rst(rst), .learn_en(learn_en), .len_sel(len_sel),
        .upd_bit(upd_bit), .rnd_mom(rnd_mom), .rnd_wgt(rnd_wgt),
        .wgt_bit(wgt_bit), .wgt_val(wgt_val)
    );

    function automatic int sat_step(int v, bit up, bit full, int w);
        int mx = (1 << w) - 1;
        int s  = full ? 1 : 2;
        if (up) return (v + s > mx) ? mx : v + s;
        return (v < s) ? 0 : v - s;
    endfunction

    function automatic bit code(int v, int r, bit full);
        if (full) return v > r;
        return (v >> 1) > (r >> 1);
    endfunction

    task automatic check_now(string tag);
        bit exp_bit;
        vectors++;
        exp_bit = code(m_w, int'(rnd_wgt), len_sel);
        if (int'(wgt_val) != m_w) begin
            miscompares++;
            $display("FAIL %s wgt_val actual=%0d expected=%0d", tag, wgt_val, m_w);
        end
        if (wgt_bit != exp_bit) begin
            miscompares++;
            $display("FAIL R7/%s wgt_bit actual=%0b expected=%0b (w=%0d r=%0d)",
                     tag, wgt_bit, exp_bit, m_w, rnd_wgt);
        end
    endtask

    task automatic model_edge();
        bit mb;
        if (learn_en) begin
            mb  = code(m_m, int'(rnd_mom), len_sel);
            m_m = sat_step(m_m, upd_bit, len_sel, WM);
            m_w = sat_step(m_w, mb, len_sel, WW);
        end
    endtask

    // kind: 0 random, 1 push high, 2 push low, 3 frozen random
    task automatic run(int n, int kind, bit full, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            len_sel = full;
            rnd_wgt = WW'($urandom);
            if (($urandom % 8) == 0) rnd_wgt = ($urandom % 2) ? '0 : '1;
            case (kind)
                1: begin learn_en = 1; upd_bit = 1; rnd_mom = '0; end
                2: begin learn_en = 1; upd_bit = 0; rnd_mom = '1; end
                3: begin learn_en = 0; upd_bit = 1'($urandom); rnd_mom = WM'($urandom); end
                default: begin
                    learn_en = ($urandom % 4) != 0;
                    upd_bit  = 1'($urandom);
                    rnd_mom  = WM'($urandom);
                end
            endcase
            #1;
            check_now(tag);
            model_edge();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; learn_en = 0; len_sel = 1; upd_bit = 0; rnd_mom = '0; rnd_wgt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_w = 1 << (WW - 1);
        m_m = 1 << (WM - 1);
        // R1: reset midpoint; momentum midpoint probed with rnd_mom just below/at it
        learn_en = 1; upd_bit = 0; rnd_mom = WM'((1 << (WM - 1)) - 1); rnd_wgt = '0;
        #1; check_now("R1");
        model_edge();
        @(negedge clk);
        rnd_mom = WM'(1 << (WM - 1)); upd_bit = 1;
        #1; check_now("R1");
        model_edge();
        run(600,  0, 1'b1, "R2");
        run(2300, 1, 1'b1, "R4");
        run(4400, 2, 1'b1, "R4");
        run(3000, 0, 1'b1, "R3");
        run(300,  3, 1'b1, "R6");
        run(3000, 0, 1'b0, "R5");
        run(300,  3, 1'b0, "R6");
        run(1100, 1, 1'b0, "R5");
        run(500,  0, 1'b1, "R8");
        run(1100, 2, 1'b0, "R5");
        run(2000, 0, 1'b1, "R3");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule